// File: doc/BRIEF.md
# Ring Interrupt Packet Receiver

This block sits at a ring node and looks at every interrupt packet that passes by. A packet carries four fields: the ID of the node that sent it, the ID of the node it targets, a 2-bit interrupt type and a 32-bit user word. The block keeps a packet when it is aimed at this node, or at every node, and when this node did not send it. It then pushes the sender ID and the user word together into one of four queue pairs. The packet's type picks the pair.

The host drains each pair through its own pop strobe. The oldest sender ID and user word are always visible at the outputs. Each type has two status bits: a pending bit that follows queue occupancy, and a sticky overflow bit that records a packet lost to a full pair. The host also sets a per-type enable register. A single interrupt line combines the pending bits that are enabled, gated by a global enable input.

Top module: `ring_irq_rx`

## Requirements
- R1: A valid packet whose target equals `node_id` and whose sender differs from `node_id` is queued as one entry in the pair selected by `pkt_type`.
- R2: A valid packet whose target is 0xFF (broadcast) is queued under the same sender rule as R1.
- R3: A packet whose target is neither `node_id` nor 0xFF changes no queue and no status bit.
- R4: A packet whose sender equals `node_id` is never queued, even when it is broadcast.
- R5: Each pair is first-in first-out. `head_src`/`head_data` for type i show the oldest entry. A pop removes one sender ID and its user word together.
- R6: A pair holds at most 127 entries. A packet accepted for a full pair is dropped, the queue contents stay unchanged and `ovf_flag[i]` is set.
- R7: `ovf_flag[i]` stays set until a cycle with `ovf_clr[i]` high and no new overflow for type i. A new overflow in the clearing cycle wins.
- R8: `pend[i]` is 1 exactly while pair i holds at least one entry.
- R9: `irq` equals `glob_en & |(pend & enable)`. The enable register loads `en_din` on a cycle with `en_we` high.
- R10: A pop of an empty pair has no effect.
- R11: After reset all pairs are empty, and the overflow flags, the enable register and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 8 | This node's ID |
| pkt_valid | input | 1 | Packet fields valid this cycle |
| pkt_src | input | 8 | Sender node ID |
| pkt_dst | input | 8 | Target node ID, 0xFF = all nodes |
| pkt_type | input | 2 | Interrupt type, selects the queue pair |
| pkt_data | input | 32 | User word |
| pop | input | 4 | Per-type pop strobe |
| head_src | output | 32 | Oldest sender ID, type i at bits [8i+7:8i] |
| head_data | output | 128 | Oldest user word, type i at bits [32i+31:32i] |
| pend | output | 4 | Per-type non-empty status |
| ovf_flag | output | 4 | Per-type sticky overflow status |
| ovf_clr | input | 4 | Per-type overflow clear |
| en_we | input | 1 | Enable register write strobe |
| en_din | input | 4 | Enable register write value |
| en_q | output | 4 | Enable register contents |
| glob_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined host interrupt |

## Verification
The checker watches four things on every cycle. Packets that are not for this node, or that this node sent, leave the pending and overflow bits alone. Popping an empty pair with no packet arriving keeps it empty. An overflow flag holds until it is cleared. The interrupt stays low while the global enable is off. Other behaviour needs a model of the queue contents, so only the bench's scenarios can show it: first-in first-out order and pairing of sender and word, the 127-entry limit with the drop leaving the contents intact, set winning over clear, and the enabled interrupt combination.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
   typedef enum logic [1:0] {
      HIT_NONE   = 2'd0,
      HIT_DIRECT = 2'd1,
      HIT_BCAST  = 2'd2,
      HIT_SELF   = 2'd3
   } hit_e;
endpackage

// File: rtl/ring_irq_match.sv
module ring_irq_match
   import ring_irq_pkg::*;
#(
   parameter int ID_W     = 8,
   parameter int BCAST_ID = 255
)(
   input  logic            valid,
   input  logic [ID_W-1:0] node_id,
   input  logic [ID_W-1:0] src,
   input  logic [ID_W-1:0] dst,
   output hit_e            hit,
   output logic            accept
);
   localparam logic [ID_W-1:0] BC = ID_W'(BCAST_ID);

   always_comb begin
      if (!valid)               hit = HIT_NONE;
      else if (src == node_id)  hit = HIT_SELF;
      else if (dst == node_id)  hit = HIT_DIRECT;
      else if (dst == BC)       hit = HIT_BCAST;
      else                      hit = HIT_NONE;
   end

   assign accept = (hit == HIT_DIRECT) || (hit == HIT_BCAST);
endmodule

// File: rtl/ring_irq_fifo.sv
module ring_irq_fifo #(
   parameter int W     = 40,
   parameter int DEPTH = 127
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= nxt(wr_ptr);
         if (pop)  rd_ptr <= nxt(rd_ptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/ring_irq_rx.sv
module ring_irq_rx
   import ring_irq_pkg::*;
#(
   parameter int ID_W      = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_TYPES = 4,
   parameter int DEPTH     = 127,
   parameter int BCAST_ID  = 255
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ID_W-1:0]             node_id,
   input  logic                        pkt_valid,
   input  logic [ID_W-1:0]             pkt_src,
   input  logic [ID_W-1:0]             pkt_dst,
   input  logic [$clog2(NUM_TYPES)-1:0] pkt_type,
   input  logic [DATA_W-1:0]           pkt_data,
   input  logic [NUM_TYPES-1:0]        pop,
   output logic [NUM_TYPES*ID_W-1:0]   head_src,
   output logic [NUM_TYPES*DATA_W-1:0] head_data,
   output logic [NUM_TYPES-1:0]        pend,
   output logic [NUM_TYPES-1:0]        ovf_flag,
   input  logic [NUM_TYPES-1:0]        ovf_clr,
   input  logic                        en_we,
   input  logic [NUM_TYPES-1:0]        en_din,
   output logic [NUM_TYPES-1:0]        en_q,
   input  logic                        glob_en,
   output logic                        irq
);
   localparam int TW = $clog2(NUM_TYPES);
   localparam int EW = ID_W + DATA_W;

   if (NUM_TYPES < 2 || (1 << TW) != NUM_TYPES) begin : g_bad_types
      $error("NUM_TYPES must be a power of two of at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (BCAST_ID >= (1 << ID_W)) begin : g_bad_bcast
      $error("BCAST_ID does not fit in ID_W");
   end

   hit_e hit;
   logic accept;

   ring_irq_match #(.ID_W(ID_W), .BCAST_ID(BCAST_ID)) u_match (
      .valid  (pkt_valid),
      .node_id(node_id),
      .src    (pkt_src),
      .dst    (pkt_dst),
      .hit    (hit),
      .accept (accept)
   );

   logic [NUM_TYPES-1:0] is_full, is_empty, do_push, do_pop, ovf_set;

   for (genvar i = 0; i < NUM_TYPES; i++) begin : g_type
      logic          sel;
      logic [EW-1:0] entry;

      assign sel        = accept && (pkt_type == TW'(i));
      assign do_push[i] = sel && !is_full[i];
      assign ovf_set[i] = sel && is_full[i];
      assign do_pop[i]  = pop[i] && !is_empty[i];

      ring_irq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
         .clk  (clk),
         .rst_n(rst_n),
         .push (do_push[i]),
         .din  ({pkt_src, pkt_data}),
         .pop  (do_pop[i]),
         .head (entry),
         .empty(is_empty[i]),
         .full (is_full[i])
      );

      assign head_src[i*ID_W +: ID_W]      = entry[EW-1 -: ID_W];
      assign head_data[i*DATA_W +: DATA_W] = entry[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_flag <= '0;
         en_q     <= '0;
      end else begin
         ovf_flag <= ovf_set | (ovf_flag & ~ovf_clr);
         if (en_we) en_q <= en_din;
      end
   end

   assign pend = ~is_empty;
   assign irq  = glob_en && |(pend & en_q);
endmodule

// File: rtl/ring_irq_rx_chk.sv
module ring_irq_rx_chk #(
   parameter int ID_W      = 8,
   parameter int NUM_TYPES = 4,
   parameter int BCAST_ID  = 255
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic [ID_W-1:0]      node_id,
   input logic                 pkt_valid,
   input logic [ID_W-1:0]      pkt_src,
   input logic [ID_W-1:0]      pkt_dst,
   input logic [NUM_TYPES-1:0] pop,
   input logic [NUM_TYPES-1:0] pend,
   input logic [NUM_TYPES-1:0] ovf_flag,
   input logic [NUM_TYPES-1:0] ovf_clr,
   input logic                 glob_en,
   input logic                 irq
);
   localparam logic [ID_W-1:0] BC = ID_W'(BCAST_ID);

   logic foreign, own;
   assign foreign = pkt_valid && pkt_dst != node_id && pkt_dst != BC;
   assign own     = pkt_valid && pkt_src == node_id;

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> !irq);

   for (genvar i = 0; i < NUM_TYPES; i++) begin : g_chk
      assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_flag[i] && !ovf_clr[i]) |=> ovf_flag[i]);

      assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!pkt_valid && pop[i] && !pend[i]) |=> !pend[i]);

      assert_foreign_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (foreign && !pop[i] && !ovf_clr[i]) |=> ($stable(pend[i]) && $stable(ovf_flag[i])));

      assert_own_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (own && !pop[i] && !ovf_clr[i]) |=> ($stable(pend[i]) && $stable(ovf_flag[i])));
   end
endmodule

bind ring_irq_rx ring_irq_rx_chk #(
   .ID_W(ID_W), .NUM_TYPES(NUM_TYPES), .BCAST_ID(BCAST_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .node_id(node_id), .pkt_valid(pkt_valid),
   .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pop(pop), .pend(pend),
   .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .glob_en(glob_en), .irq(irq)
);

// File: tb/sim_ring_irq_rx.sv
`timescale 1ns/1ps
module sim_ring_irq_rx;
   localparam int NT = 4;
   localparam int DEPTH = 127;
   localparam logic [7:0] ME = 8'h23;

   logic clk = 0, rst_n = 0;
   logic [7:0] node_id = ME;
   logic pkt_valid = 0;
   logic [7:0] pkt_src = 0, pkt_dst = 0;
   logic [1:0] pkt_type = 0;
   logic [31:0] pkt_data = 0;
   logic [NT-1:0] pop = 0, ovf_clr = 0, en_din = 0;
   logic en_we = 0, glob_en = 0;
   logic [NT*8-1:0] head_src;
   logic [NT*32-1:0] head_data;
   logic [NT-1:0] pend, ovf_flag, en_q;
   logic irq;

   always #2 clk = ~clk;

   ring_irq_rx u0 (.*);

   int errors = 0, checks = 0;
   bit done = 0;
   logic [39:0] q [NT][$];
   logic [NT-1:0] m_ovf = 0, m_en = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NT-1:0] m_pend();
      logic [NT-1:0] p;
      for (int i = 0; i < NT; i++) p[i] = (q[i].size() != 0);
      return p;
   endfunction

   task automatic compare();
      logic [NT-1:0] p = m_pend();
      for (int i = 0; i < NT; i++) begin
         chk(pend[i] == p[i], "R8", 64'(pend[i]), 64'(p[i]));
         chk(ovf_flag[i] == m_ovf[i], "R7", 64'(ovf_flag[i]), 64'(m_ovf[i]));
         if (p[i]) chk({head_src[i*8 +: 8], head_data[i*32 +: 32]} == q[i][0], "R5",
                       64'({head_src[i*8 +: 8], head_data[i*32 +: 32]}), 64'(q[i][0]));
      end
      chk(en_q == m_en, "R9", 64'(en_q), 64'(m_en));
      chk(irq == (glob_en && |(p & m_en)), "R9", 64'(irq), 64'(glob_en && |(p & m_en)));
   endtask

   // model update from the inputs currently driven, then one clock
   task automatic tick();
      bit acc = pkt_valid && pkt_src != ME && (pkt_dst == ME || pkt_dst == 8'hFF);
      logic [NT-1:0] oset = 0;
      for (int i = 0; i < NT; i++) begin
         bit full = (q[i].size() == DEPTH);
         if (pop[i] && q[i].size() != 0) void'(q[i].pop_front());
         if (acc && pkt_type == i) begin
            if (full) oset[i] = 1;
            else q[i].push_back({pkt_src, pkt_data});
         end
      end
      m_ovf = oset | (m_ovf & ~ovf_clr);
      if (en_we) m_en = en_din;
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic quiet();
      pkt_valid = 0; pop = 0; ovf_clr = 0; en_we = 0;
   endtask

   task automatic send(input logic [7:0] s, input logic [7:0] d, input logic [1:0] t, input logic [31:0] w);
      quiet();
      pkt_valid = 1; pkt_src = s; pkt_dst = d; pkt_type = t; pkt_data = w;
      tick();
      quiet();
   endtask

   initial begin
      #700000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(pend == 0 && ovf_flag == 0 && en_q == 0 && irq == 0, "R11",
          64'({pend, ovf_flag, en_q, irq}), 64'd0);
      rst_n = 1;
      tick();
      // R1 directed
      send(8'h10, ME, 2'd1, 32'hA1A1_0001);
      chk(pend == 4'b0010, "R1", 64'(pend), 64'h2);
      // R2 broadcast
      send(8'h11, 8'hFF, 2'd3, 32'hB2B2_0002);
      chk(pend == 4'b1010, "R2", 64'(pend), 64'hA);
      // R3 foreign target
      send(8'h12, 8'h40, 2'd0, 32'h0);
      chk(pend == 4'b1010, "R3", 64'(pend), 64'hA);
      // R4 own sender, broadcast
      send(ME, 8'hFF, 2'd0, 32'h0);
      chk(pend == 4'b1010, "R4", 64'(pend), 64'hA);
      // R10 pop of empty pair 0
      quiet(); pop = 4'b0001; tick(); quiet();
      chk(pend == 4'b1010, "R10", 64'(pend), 64'hA);
      // R9 enables
      en_we = 1; en_din = 4'b1000; glob_en = 1; tick(); quiet();
      chk(irq == 1, "R9", 64'(irq), 64'd1);
      // R6 fill type 2 beyond capacity
      for (int k = 0; k < DEPTH + 2; k++) send(8'h30 + 8'(k % 7), ME, 2'd2, 32'(k));
      chk(ovf_flag[2] == 1, "R6", 64'(ovf_flag[2]), 64'd1);
      chk(head_data[2*32 +: 32] == 32'd0, "R6", 64'(head_data[2*32 +: 32]), 64'd0);
      // R7 clear in the same cycle as another overflow: set wins
      pkt_valid = 1; pkt_src = 8'h31; pkt_dst = ME; pkt_type = 2'd2; ovf_clr = 4'b0100;
      tick(); quiet();
      chk(ovf_flag[2] == 1, "R7", 64'(ovf_flag[2]), 64'd1);
      ovf_clr = 4'b0100; tick(); quiet();
      chk(ovf_flag[2] == 0, "R7", 64'(ovf_flag[2]), 64'd0);
      // random phase
      for (int c = 0; c < 6000; c++) begin
         int r = $urandom % 8;
         quiet();
         pkt_valid = ($urandom % 4) != 0;
         pkt_src = (($urandom % 8) == 0) ? ME : 8'($urandom);
         pkt_dst = (r < 3) ? ME : (r < 5) ? 8'hFF : 8'($urandom);
         pkt_type = 2'($urandom);
         pkt_data = $urandom;
         pop = 4'($urandom) & 4'($urandom);
         ovf_clr = (($urandom % 16) == 0) ? 4'($urandom) : 4'b0;
         en_we = ($urandom % 32) == 0;
         en_din = 4'($urandom);
         if (($urandom % 64) == 0) glob_en = ~glob_en;
         tick();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule